// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds eight 32-bit general-purpose registers. It has one write port and two independent read ports. Every access carries a part selector, which picks one of four views of the register: the whole 32-bit word, the low half-word (bits 15:0), the low byte (bits 7:0), or the byte just above it (bits 15:8). A narrow write changes only the bits it selects. A narrow read returns the selected bits, zero-extended to 32 bits.

The byte views exist only on registers 0 to 3. Registers 4 to 7 accept only word and half-word access. A byte selector aimed at one of those registers is illegal. On a read port, the illegal access raises that port's error flag and the read data is zero. On the write port, it raises the write error flag and the register is not changed.

Writes take effect at the clock edge. Reads are combinational and show the contents from before that edge. A synchronous active-high reset clears every register to zero.

Top module: `gpr_partial_file`

## Requirements
- R1: After a synchronous reset, every register reads as 0x00000000 through either read port with the word selector.
- R2: Selector encoding: 2'b00 = word (bits 31:0), 2'b01 = half-word (bits 15:0), 2'b10 = low byte (bits 7:0), 2'b11 = high byte (bits 15:8). A word write with wr_en high replaces all 32 bits of the addressed register at the next rising edge.
- R3: A half-word write changes bits 15:0 only and keeps bits 31:16.
- R4: A low-byte write changes bits 7:0 only, taking them from wr_data[7:0]. A high-byte write changes bits 15:8 only, also taking them from wr_data[7:0]. Either byte write keeps all other bits.
- R5: A read returns the selected bits in the low end of rd_data and zeros above them. A high-byte read returns bits 15:8 in rd_data[7:0].
- R6: A byte selector (2'b10 or 2'b11) with a register index of 4 to 7 on the write port, while wr_en is high, sets wr_err in that same cycle and leaves the register unchanged.
- R7: A byte selector with a register index of 4 to 7 on a read port sets that port's error output and forces that port's read data to zero. The other read port is unaffected.
- R8: A read of a register that is being written in the same cycle returns the value from before the write. The new value is visible from the next cycle on.
- R9: With wr_en low, no register changes and wr_err stays low, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register to write |
| wr_part | input | 2 | Write part selector |
| wr_data | input | 32 | Write data; narrow writes use the low bits |
| wr_err | output | 1 | Illegal write selector this cycle |
| ra_idx | input | 3 | Read port A register |
| ra_part | input | 2 | Read port A part selector |
| ra_data | output | 32 | Read port A data, zero-extended |
| ra_err | output | 1 | Illegal read selector on port A |
| rb_idx | input | 3 | Read port B register |
| rb_part | input | 2 | Read port B part selector |
| rb_data | output | 32 | Read port B data, zero-extended |
| rb_err | output | 1 | Illegal read selector on port B |

## Verification
Two functions can fall in the same cycle. A narrow write can merge into a register while a read port is looking at that same register, and an illegal byte request can arrive on one port while a legal access uses another.

The bench provokes the first by reading the register it is writing in the same cycle. It checks that the read data is the old value before the edge and the merged value after it. It provokes the second by pairing an illegal byte read on one port with a legal read on the other, and an illegal byte write with reads. It checks that only the offending port flags, and that the unrelated data and the register contents are untouched.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int unsigned NREG  = 8;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned IDXW  = $clog2(NREG);
    localparam int unsigned NBYTE = 4;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [IDXW-1:0] idx_t;

    typedef enum logic [1:0] {
        PART_WORD = 2'b00,
        PART_HALF = 2'b01,
        PART_LOB  = 2'b10,
        PART_HIB  = 2'b11
    } part_e;

    typedef struct packed {
        idx_t  idx;
        part_e part;
    } access_t;

    function automatic logic is_byte(input part_e p);
        return (p == PART_LOB) || (p == PART_HIB);
    endfunction

    function automatic logic access_legal(input access_t a);
        return !(is_byte(a.part) && (int'(a.idx) >= NBYTE));
    endfunction

    // Bit mask that a part selector covers, in register position.
    function automatic word_t part_mask(input part_e p);
        case (p)
            PART_WORD: return '1;
            PART_HALF: return word_t'(32'h0000_FFFF);
            PART_LOB:  return word_t'(32'h0000_00FF);
            default:   return word_t'(32'h0000_FF00);
        endcase
    endfunction
endpackage

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
(
    input  word_t old_val,
    input  part_e part,
    input  word_t wdata,
    output word_t new_val
);
    word_t aligned;
    word_t mask;

    always_comb begin
        aligned = (part == PART_HIB) ? {wdata[XLEN-9:0], 8'h00} : wdata;
        mask    = part_mask(part);
        new_val = (old_val & ~mask) | (aligned & mask);
    end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  word_t   regs [NREG],
    input  access_t acc,
    output word_t   data,
    output logic    err
);
    word_t raw;

    always_comb begin
        raw = regs[acc.idx];
        err = !access_legal(acc);
        data = '0;
        if (!err) begin
            case (acc.part)
                PART_WORD: data = raw;
                PART_HALF: data = {{(XLEN-16){1'b0}}, raw[15:0]};
                PART_LOB:  data = {{(XLEN-8){1'b0}}, raw[7:0]};
                default:   data = {{(XLEN-8){1'b0}}, raw[15:8]};
            endcase
        end
    end
endmodule

// File: rtl/gpr_partial_file.sv
module gpr_partial_file
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_idx,
    input  logic [1:0]  wr_part,
    input  logic [31:0] wr_data,
    output logic        wr_err,
    input  logic [2:0]  ra_idx,
    input  logic [1:0]  ra_part,
    output logic [31:0] ra_data,
    output logic        ra_err,
    input  logic [2:0]  rb_idx,
    input  logic [1:0]  rb_part,
    output logic [31:0] rb_data,
    output logic        rb_err
);
    localparam int unsigned NPORT = 2;

    word_t   regs [NREG];
    access_t wacc;
    word_t   merged;
    logic    wlegal;

    assign wacc   = '{idx: wr_idx, part: part_e'(wr_part)};
    assign wlegal = access_legal(wacc);
    assign wr_err = wr_en && !wlegal;

    gpr_write_merge u_merge (
        .old_val(regs[wr_idx]),
        .part   (wacc.part),
        .wdata  (wr_data),
        .new_val(merged)
    );

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[r] <= '0;
                else if (wr_en && wlegal && (int'(wr_idx) == r))
                    regs[r] <= merged;
            end
        end
    endgenerate

    access_t racc [NPORT];
    word_t   rdat [NPORT];
    logic    rerr [NPORT];

    assign racc[0] = '{idx: ra_idx, part: part_e'(ra_part)};
    assign racc[1] = '{idx: rb_idx, part: part_e'(rb_part)};

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_rd
            gpr_read_port u_rd (
                .regs(regs),
                .acc (racc[p]),
                .data(rdat[p]),
                .err (rerr[p])
            );
        end
    endgenerate

    assign ra_data = rdat[0];
    assign ra_err  = rerr[0];
    assign rb_data = rdat[1];
    assign rb_err  = rerr[1];
endmodule

// File: rtl/gpr_partial_file_chk.sv
module gpr_partial_file_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_idx,
    input logic [1:0]  wr_part,
    input logic [31:0] wr_data,
    input logic        wr_err,
    input logic [2:0]  ra_idx,
    input logic [1:0]  ra_part,
    input logic [31:0] ra_data,
    input logic        ra_err,
    input logic [2:0]  rb_idx,
    input logic [1:0]  rb_part,
    input logic [31:0] rb_data,
    input logic        rb_err
);
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    // R1: a cycle after reset, a word read shows zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!started)
        $past(rst) && !rst && ra_part == 2'b00 |-> ra_data == 32'h0);

    // R5: narrow reads are zero-extended
    a_r5_zero_ext_a: assert property (@(posedge clk) disable iff (rst)
        ra_part != 2'b00 |-> ra_data[31:16] == 16'h0);
    a_r5_zero_ext_b: assert property (@(posedge clk) disable iff (rst)
        rb_part[1] |-> rb_data[31:8] == 24'h0);

    // R7: illegal byte read flags and zeroes data
    a_r7_bad_read: assert property (@(posedge clk) disable iff (rst)
        ra_part[1] && ra_idx[2] |-> ra_err && ra_data == 32'h0);

    // R9: no write enable, no error
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_err);

    // R8/R9: with no write, a repeated word read is stable
    a_r9_hold: assert property (@(posedge clk) disable iff (rst || !started)
        !$past(rst) && !$past(wr_en) && $stable(ra_idx) && ra_part == 2'b00 && $past(ra_part) == 2'b00
        |-> $stable(ra_data));
endmodule

bind gpr_partial_file gpr_partial_file_chk u_chk (.*);

// File: tb/test_gpr_partial_file.sv
module test_gpr_partial_file;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_idx = 0;
    logic [1:0]  wr_part = 0;
    logic [31:0] wr_data = 0;
    logic        wr_err;
    logic [2:0]  ra_idx = 0;
    logic [1:0]  ra_part = 0;
    logic [31:0] ra_data;
    logic        ra_err;
    logic [2:0]  rb_idx = 0;
    logic [1:0]  rb_part = 0;
    logic [31:0] rb_data;
    logic        rb_err;

    always #2 clk = ~clk;

    gpr_partial_file i_gpr_partial_file (.*);

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [8];

    // vector: idx, part, data
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {3'd0, 2'b00, 32'h1122_3344},
        {3'd0, 2'b01, 32'hFFFF_AABB},
        {3'd0, 2'b10, 32'h0000_00CC},
        {3'd0, 2'b11, 32'h0000_00DD},
        {3'd1, 2'b11, 32'hFFFF_FF5A},
        {3'd3, 2'b10, 32'h0000_0077},
        {3'd4, 2'b00, 32'hDEAD_BEEF},
        {3'd4, 2'b01, 32'h0000_1234},
        {3'd5, 2'b10, 32'h0000_0099},
        {3'd6, 2'b11, 32'h0000_0088},
        {3'd7, 2'b01, 32'hCAFE_F00D},
        {3'd2, 2'b00, 32'h8000_0001}
    };

    function automatic logic [31:0] m_merge(input logic [31:0] o, input logic [1:0] p, input logic [31:0] d);
        case (p)
            2'b00: return d;
            2'b01: return {o[31:16], d[15:0]};
            2'b10: return {o[31:8], d[7:0]};
            default: return {o[31:16], d[7:0], o[7:0]};
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] v, input logic [1:0] p);
        case (p)
            2'b00: return v;
            2'b01: return {16'h0, v[15:0]};
            2'b10: return {24'h0, v[7:0]};
            default: return {24'h0, v[15:8]};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic word_check(input string req);
        for (int r = 0; r < 8; r++) begin
            ra_idx = 3'(r); ra_part = 2'b00; #0.5;
            chk(req, ra_data, model[r]);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) model[r] = 32'hFFFF_FFFF;
        // Dirty the registers before reset so R1 is meaningful.
        rst = 0;
        for (int r = 0; r < 8; r++) begin
            wr_en = 1; wr_idx = 3'(r); wr_part = 2'b00; wr_data = 32'hFFFF_FFFF; cyc();
        end
        wr_en = 0; rst = 1; cyc(); cyc(); rst = 0;
        for (int r = 0; r < 8; r++) model[r] = 0;
        // R1 reset state
        word_check("R1");

        // Vector walk: R2 R3 R4 and R6 on illegal byte writes
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  vi;
            logic [1:0]  vp;
            logic [31:0] vd;
            logic        bad;
            {vi, vp, vd} = VEC[i];
            bad = vp[1] && vi[2];
            wr_en = 1; wr_idx = vi; wr_part = vp; wr_data = vd; #0.5;
            chk("R6", {31'h0, wr_err}, {31'h0, bad});
            cyc(); wr_en = 0;
            if (!bad) model[vi] = m_merge(model[vi], vp, vd);
            ra_idx = vi; ra_part = 2'b00; #0.5;
            chk(vp == 2'b00 ? "R2" : vp == 2'b01 ? "R3" : bad ? "R6" : "R4", ra_data, model[vi]);
        end

        // R5 zero-extended narrow reads on both ports
        for (int r = 0; r < 4; r++) begin
            for (int p = 1; p < 4; p++) begin
                ra_idx = 3'(r); ra_part = 2'(p); rb_idx = 3'(r); rb_part = 2'(p); #0.5;
                chk("R5", ra_data, m_read(model[r], 2'(p)));
                chk("R5", rb_data, m_read(model[r], 2'(p)));
            end
        end
        ra_idx = 3'd4; ra_part = 2'b01; #0.5;
        chk("R5", ra_data, {16'h0, model[4][15:0]});

        // R7 illegal read on A, legal on B
        ra_idx = 3'd5; ra_part = 2'b11; rb_idx = 3'd4; rb_part = 2'b00; #0.5;
        chk("R7", {31'h0, ra_err}, 32'h1);
        chk("R7", ra_data, 32'h0);
        chk("R7", {31'h0, rb_err}, 32'h0);
        chk("R7", rb_data, model[4]);
        ra_idx = 3'd0; ra_part = 2'b10; rb_idx = 3'd7; rb_part = 2'b10; #0.5;
        chk("R7", {31'h0, rb_err}, 32'h1);
        chk("R7", rb_data, 32'h0);
        chk("R7", ra_data, {24'h0, model[0][7:0]});

        // R8 read during write sees the old value
        cyc();
        wr_en = 1; wr_idx = 3'd1; wr_part = 2'b10; wr_data = 32'h0000_00E1;
        ra_idx = 3'd1; ra_part = 2'b00; #0.5;
        chk("R8", ra_data, model[1]);
        cyc(); wr_en = 0;
        model[1] = m_merge(model[1], 2'b10, 32'hE1);
        ra_idx = 3'd1; #0.5;
        chk("R8", ra_data, model[1]);

        // R6 illegal write in parallel with reads: nothing changes
        cyc();
        wr_en = 1; wr_idx = 3'd6; wr_part = 2'b10; wr_data = 32'h0000_0042; #0.5;
        chk("R6", {31'h0, wr_err}, 32'h1);
        cyc(); wr_en = 0;
        word_check("R6");

        // R9 write inputs toggled without enable
        wr_en = 0; wr_idx = 3'd2; wr_part = 2'b00; wr_data = 32'h5555_AAAA; #0.5;
        chk("R9", {31'h0, wr_err}, 32'h0);
        cyc();
        wr_idx = 3'd7; wr_part = 2'b11; #0.5;
        chk("R9", {31'h0, wr_err}, 32'h0);
        cyc();
        word_check("R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule